// File: doc/BRIEF.md
# Memory Sparing Control and Status Registers

This block is the software-visible register unit for one shared spare-copy engine in a memory controller. It also reports when the patrol scrubber finishes a pass. Software reaches it through a plain 32-bit register port with two words:

- A control word. It arms a spare-copy operation and picks the source channel, or the channel pair.
- A status word. It reports progress, completion and patrol passes.

The copy engine and the patrol scrubber sit outside the block. They reach it only through four handshake inputs (started, done, failed, patrol wrap). The block drives two outputs back to them: a one-cycle start request and a channel mask.

The 2-bit channel field is read in one of two ways:

- In independent-channel mode it names one of four channels.
- In lock-step mode only its upper bit counts, and it names the pair {0,1} or the pair {2,3}.

The field and the mode are captured when an operation is accepted. Both are held until the operation ends, so later writes cannot move a copy that is running. The enable bit clears itself when the engine reports done or failed. Arming is refused while a second sparing enable from a neighbouring controller is high.

Top module: `spare_csr_unit`

## Requirements
- R1: The control word sits at offset 0x00 and resets to 0. Bit 0 reads the enable, bits 3:2 read the channel field last written, and bit 1 and bits 31:4 read as 0.
- R2: `chan_mask` is derived from the captured field `s` and mode. In independent mode it is the one-hot value 1<<s. In lock-step mode it is 4'b0011 when s[1]=0 and 4'b1100 when s[1]=1. After reset it shows 4'b0001.
- R3: A control write with bit 0 = 1 is accepted only if all of these hold: the enable is 0, and `peer_spare_en` is 0. On acceptance the enable reads 1 from the next cycle. The enable clears on the cycle after `eng_done` or `eng_failed` is seen while it is 1. Writing bit 0 = 0 has no effect on it.
- R4: `start_req` is high for exactly one cycle, the cycle after an accepted write. A write with bit 0 = 1 while the enable is already 1 makes no pulse.
- R5: While `peer_spare_en` is 1, a write with bit 0 = 1 neither sets the enable nor pulses `start_req`.
- R6: Status bit 0 (in progress) sits at offset 0x04 and is read-only. It is set by `eng_started` while the enable is 1. It is cleared by `eng_done` or `eng_failed` while the enable is 1, and the clear wins over a simultaneous start.
- R7: Status bit 1 (complete) is read-only. It is set by `eng_done` while the enable is 1 and `eng_failed` is 0. It is cleared by an accepted new operation. A failure leaves it at 0, and failed wins over a simultaneous done.
- R8: Status bit 2 (patrol pass) is set by `patrol_wrap` and cleared by writing 1 to bit 2 of the status word. A set in the same cycle as the clear wins. Writes to the other status bits have no effect.
- R9: While an operation runs, writes to the channel field change the value read back but not `chan_mask`. Changes to `lockstep_mode` do not change `chan_mask` either.
- R10: Status bits 31:3 read as 0. Any offset other than 0x00 and 0x04 reads as 0.
- R11: `eng_done` or `eng_failed` arriving while the enable is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| lockstep_mode | input | 1 | 1 = channels run in lock-step pairs |
| peer_spare_en | input | 1 | Sparing enable of the other controller (mutual exclusion) |
| eng_started | input | 1 | Copy engine has begun the operation |
| eng_done | input | 1 | Copy engine finished successfully |
| eng_failed | input | 1 | Copy engine aborted |
| patrol_wrap | input | 1 | Patrol scrubber finished a full pass |
| start_req | output | 1 | One-cycle request to start the copy engine |
| chan_mask | output | 4 | Channel(s) selected for the running copy |

## Verification
A stuck or wrongly cleared enable shows on the control word on the next cycle after the write or engine event. It also shows as a missing or doubled `start_req` pulse. A captured channel that moves mid-copy appears on `chan_mask` in the cycle after the offending write. Wrong flag priority (start against done, done against failed, wrap against clear) shows in the status word one cycle after the collision. Because of this, the bench compares the ports with a behavioural model on every clock.

// File: rtl/spare_csr_pkg.sv
// Package: shared constants for the sparing register unit.
// Assumes 32-bit register data and byte offsets on an 8-bit address.
package spare_csr_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int NUM_CH   = 4;
    localparam int SEL_W    = $clog2(NUM_CH);
    localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h00;
    localparam logic [ADDR_W-1:0] STAT_OFS = 8'h04;

    // Bit positions inside the control word
    localparam int C_EN_BIT  = 0;
    localparam int C_SEL_LSB = 2;
    // Bit positions inside the status word
    localparam int S_BUSY_BIT = 0;
    localparam int S_DONE_BIT = 1;
    localparam int S_PTRL_BIT = 2;

    typedef struct packed {
        logic busy;
        logic done;
        logic patrol;
    } stat_flags_t;
endpackage

// File: rtl/spare_chan_decode.sv
// Module: spare_chan_decode
// Turns a captured channel field and a mode bit into a per-channel mask.
// Assumes NUM_CH is a power of two of at least 2. In pair mode channel i
// belongs to pair i>>1, and the pair index is the field without its LSB.
module spare_chan_decode #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = $clog2(NUM_CH)
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              pair_mode,
    output logic [NUM_CH-1:0] mask
);
    localparam int PAIR_W = (SEL_W > 1) ? SEL_W - 1 : 1;

    logic [PAIR_W-1:0] pair_idx;

    // Pair index: the field with its low bit dropped
    always_comb pair_idx = PAIR_W'(sel >> 1);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic single_hit;
        logic pair_hit;
        // Per-channel hit in each mode
        always_comb begin
            single_hit = (sel == SEL_W'(i));
            pair_hit   = (pair_idx == PAIR_W'(i >> 1));
            mask[i]    = pair_mode ? pair_hit : single_hit;
        end
    end
endmodule

// File: rtl/spare_ctrl_reg.sv
// Module: spare_ctrl_reg
// Holds the control word (enable and channel field), decides whether an
// arming write is accepted, captures the channel and mode for the run,
// and issues the one-cycle start request.
// Assumes the engine reports done/failed only for an operation it was started for.
module spare_ctrl_reg #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wdata_en,
    input  logic [SEL_W-1:0] wdata_sel,
    input  logic             peer_en,
    input  logic             lockstep_in,
    input  logic             op_done,
    input  logic             op_failed,
    output logic             en_q,
    output logic [SEL_W-1:0] sel_q,
    output logic [SEL_W-1:0] act_sel_q,
    output logic             act_ls_q,
    output logic             accept,
    output logic             start_q
);
    logic op_end;

    // Acceptance of an arming write and end-of-run detection
    always_comb begin
        accept = wr_ctrl && wdata_en && !en_q && !peer_en;
        op_end = en_q && (op_done || op_failed);
    end

    // Software-visible channel field follows every control write
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= '0;
        else if (wr_ctrl) sel_q <= wdata_sel;
    end

    // Enable: set on acceptance, cleared by the engine at run end
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (accept) en_q <= 1'b1;
        else if (op_end) en_q <= 1'b0;
    end

    // Channel and mode captured at acceptance, held for the whole run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel_q <= '0;
            act_ls_q  <= 1'b0;
        end else if (accept) begin
            act_sel_q <= wdata_sel;
            act_ls_q  <= lockstep_in;
        end
    end

    // Start request pulse, one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= accept;
    end

    // R4: the start request never lasts two cycles
    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);

    // R5: a write blocked by the peer enable makes no pulse and no enable
    p_peer_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata_en && peer_en && !en_q) |=> (!start_q && !en_q));

    // R3: enable drops right after a done or fail while armed
    p_en_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && (op_done || op_failed)) |=> !en_q);
endmodule

// File: rtl/spare_status_reg.sv
// Module: spare_status_reg
// Keeps the three status flags: in progress, complete, patrol pass.
// Assumes en_q and accept come from the control register in the same cycle.
module spare_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic accept,
    input  logic started,
    input  logic done,
    input  logic failed,
    input  logic patrol_wrap,
    input  logic patrol_w1c,
    output spare_csr_pkg::stat_flags_t flags
);
    // In-progress flag: start sets, done/fail clear (clear wins)
    always_ff @(posedge clk) begin
        if (!rst_n)                          flags.busy <= 1'b0;
        else if (en_q && (done || failed))   flags.busy <= 1'b0;
        else if (en_q && started)            flags.busy <= 1'b1;
    end

    // Complete flag: success sets, a new accepted operation clears
    always_ff @(posedge clk) begin
        if (!rst_n)                          flags.done <= 1'b0;
        else if (accept)                     flags.done <= 1'b0;
        else if (en_q && done && !failed)    flags.done <= 1'b1;
    end

    // Patrol flag: wrap sets, write-one clears, set wins on collision
    always_ff @(posedge clk) begin
        if (!rst_n)           flags.patrol <= 1'b0;
        else if (patrol_wrap) flags.patrol <= 1'b1;
        else if (patrol_w1c)  flags.patrol <= 1'b0;
    end

    // R6: in-progress can only be seen while the enable is held
    p_busy_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags.busy |-> en_q);

    // R7: a failure never reports completion
    p_fail_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && failed) |=> !flags.done);

    // R8: a patrol wrap is never lost
    p_patrol_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        patrol_wrap |=> flags.patrol);
endmodule

// File: rtl/spare_csr_unit.sv
// Module: spare_csr_unit (top)
// Register unit for the shared spare-copy engine: control word at 0x00,
// status word at 0x04, combinational read-back, and the start and channel
// outputs to the engine.
// Assumes full 32-bit accesses and no read side effects.
module spare_csr_unit
    import spare_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lockstep_mode,
    input  logic              peer_spare_en,
    input  logic              eng_started,
    input  logic              eng_done,
    input  logic              eng_failed,
    input  logic              patrol_wrap,
    output logic              start_req,
    output logic [3:0]        chan_mask
);
    logic             hit_ctrl, hit_stat;
    logic             wr_ctrl, wr_stat;
    logic             en_q, accept, act_ls_q;
    logic [SEL_W-1:0] sel_q, act_sel_q;
    stat_flags_t      flags;

    // Address decode for reads and writes
    always_comb begin
        hit_ctrl = (reg_addr == CTRL_OFS);
        hit_stat = (reg_addr == STAT_OFS);
        wr_ctrl  = reg_wr && hit_ctrl;
        wr_stat  = reg_wr && hit_stat;
    end

    spare_ctrl_reg #(.SEL_W(SEL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wdata_en    (reg_wdata[C_EN_BIT]),
        .wdata_sel   (reg_wdata[C_SEL_LSB +: SEL_W]),
        .peer_en     (peer_spare_en),
        .lockstep_in (lockstep_mode),
        .op_done     (eng_done),
        .op_failed   (eng_failed),
        .en_q        (en_q),
        .sel_q       (sel_q),
        .act_sel_q   (act_sel_q),
        .act_ls_q    (act_ls_q),
        .accept      (accept),
        .start_q     (start_req)
    );

    spare_status_reg u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_q        (en_q),
        .accept      (accept),
        .started     (eng_started),
        .done        (eng_done),
        .failed      (eng_failed),
        .patrol_wrap (patrol_wrap),
        .patrol_w1c  (wr_stat && reg_wdata[S_PTRL_BIT]),
        .flags       (flags)
    );

    spare_chan_decode #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dec (
        .sel       (act_sel_q),
        .pair_mode (act_ls_q),
        .mask      (chan_mask)
    );

    // Read-back multiplexer; unmapped offsets read zero
    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl) begin
            reg_rdata[C_EN_BIT]              = en_q;
            reg_rdata[C_SEL_LSB +: SEL_W]    = sel_q;
        end else if (hit_stat) begin
            reg_rdata[S_BUSY_BIT] = flags.busy;
            reg_rdata[S_DONE_BIT] = flags.done;
            reg_rdata[S_PTRL_BIT] = flags.patrol;
        end
    end

    // R9: the channel mask holds while an operation stays armed
    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> (!en_q || $stable(chan_mask)));

    // R2: the mask is never empty
    p_mask_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chan_mask != 4'b0000);
endmodule

// File: tb/spare_csr_unit_tb.sv
// Bench: behavioural reference model, compared with the ports every clock.
module spare_csr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lockstep_mode = 1'b0, peer_spare_en = 1'b0;
    logic        eng_started = 1'b0, eng_done = 1'b0, eng_failed = 1'b0;
    logic        patrol_wrap = 1'b0;
    logic        start_req;
    logic [3:0]  chan_mask;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Reference model state
    bit       m_en, m_busy, m_cmp, m_ptrl, m_start, m_als;
    bit [1:0] m_sel, m_asel;

    always #5 clk = ~clk;

    spare_csr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lockstep_mode(lockstep_mode), .peer_spare_en(peer_spare_en),
        .eng_started(eng_started), .eng_done(eng_done), .eng_failed(eng_failed),
        .patrol_wrap(patrol_wrap), .start_req(start_req), .chan_mask(chan_mask)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] mdl_mask();
        if (m_als) return m_asel[1] ? 4'b1100 : 4'b0011;
        return 4'b0001 << m_asel;
    endfunction

    // Model update at a clock edge from the inputs held during the cycle
    task automatic mdl_tick();
        bit acc, fin;
        if (!rst_n) begin
            m_en = 0; m_busy = 0; m_cmp = 0; m_ptrl = 0; m_start = 0;
            m_als = 0; m_sel = 0; m_asel = 0;
            return;
        end
        acc = reg_wr && reg_addr == 8'h00 && reg_wdata[0] && !m_en && !peer_spare_en;
        fin = m_en && (eng_done || eng_failed);
        if (reg_wr && reg_addr == 8'h00) m_sel = reg_wdata[3:2];
        if (acc) begin m_asel = reg_wdata[3:2]; m_als = lockstep_mode; end
        if (acc) m_cmp = 0;
        else if (m_en && eng_done && !eng_failed) m_cmp = 1;
        if (fin) m_busy = 0;
        else if (m_en && eng_started) m_busy = 1;
        if (patrol_wrap) m_ptrl = 1;
        else if (reg_wr && reg_addr == 8'h04 && reg_wdata[2]) m_ptrl = 0;
        if (acc) m_en = 1; else if (fin) m_en = 0;
        m_start = acc;
    endtask

    // Compare all ports against the model (read data for current address)
    task automatic compare_all();
        chk("R4", "start_req", {31'b0, start_req}, {31'b0, m_start});
        chk(m_en ? "R9" : "R2", "chan_mask", {28'b0, chan_mask}, {28'b0, mdl_mask()});
        if (reg_addr == 8'h00) begin
            chk("R3", "ctrl.en", {31'b0, reg_rdata[0]}, {31'b0, m_en});
            chk("R1", "ctrl.field", {30'b0, reg_rdata[3:2]}, {30'b0, m_sel});
            chk("R1", "ctrl.reserved", {reg_rdata[31:4], reg_rdata[1]}, '0);
        end else if (reg_addr == 8'h04) begin
            chk("R6", "stat.busy", {31'b0, reg_rdata[0]}, {31'b0, m_busy});
            chk("R7", "stat.complete", {31'b0, reg_rdata[1]}, {31'b0, m_cmp});
            chk("R8", "stat.patrol", {31'b0, reg_rdata[2]}, {31'b0, m_ptrl});
            chk("R10", "stat.reserved", {3'b0, reg_rdata[31:3]}, '0);
        end else begin
            chk("R10", "unmapped", reg_rdata, '0);
        end
    endtask

    // One cycle: drive inputs, clock model, compare at the falling edge
    task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input bit st = 0, input bit dn = 0, input bit fl = 0,
                        input bit pw = 0, input bit pe = 0, input bit ls = 0);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        eng_started = st; eng_done = dn; eng_failed = fl;
        patrol_wrap = pw; peer_spare_en = pe; lockstep_mode = ls;
        @(posedge clk);
        mdl_tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic rd(input logic [7:0] a);
        step(0, a, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) begin @(posedge clk); mdl_tick(); @(negedge clk); end
        rst_n = 1'b1;
        // R1, R10: reset state and reserved/unmapped reads
        rd(8'h00); rd(8'h04); rd(8'h08); rd(8'hFC);
        // R3, R4, R9: independent arm on channel 2, rewrites during run
        step(1, 8'h00, 32'h0000_0009);
        rd(8'h00);
        step(0, 8'h04, '0, 1);                    // started
        step(1, 8'h00, 32'h0000_0005);            // R4: no second pulse, R9
        step(1, 8'h00, 32'h0000_0000);            // R3: writing 0 ignored
        rd(8'h00); rd(8'h04);
        step(0, 8'h04, '0, 0, 1);                 // done
        rd(8'h04); rd(8'h00);
        // R11: engine events while idle
        step(0, 8'h04, '0, 1, 1, 1);
        rd(8'h04); rd(8'h00);
        // R2: lock-step pair 2/3, then failure (R7)
        step(1, 8'h00, 32'h0000_000D, 0, 0, 0, 0, 0, 1);
        step(0, 8'h04, '0, 1, 0, 0, 0, 0, 0);     // mode change ignored (R9)
        step(0, 8'h04, '0, 0, 1, 1);              // done+fail: fail wins
        rd(8'h04); rd(8'h00);
        // R2: lock-step pair 0/1, started with done same cycle (R6)
        step(1, 8'h00, 32'h0000_0005, 0, 0, 0, 0, 0, 1);
        step(0, 8'h04, '0, 1, 1);
        rd(8'h04);
        // R5: peer enable blocks arming
        step(1, 8'h00, 32'h0000_0001, 0, 0, 0, 0, 1);
        rd(8'h00);
        chk("R5", "blocked start", {31'b0, start_req}, 32'h0);
        // R8: patrol wrap, clear, collision, other-bit writes
        step(0, 8'h04, '0, 0, 0, 0, 1);
        step(1, 8'h04, 32'h0000_0003);            // no clear of patrol
        rd(8'h04);
        step(1, 8'h04, 32'h0000_0004);            // W1C
        rd(8'h04);
        step(1, 8'h04, 32'h0000_0004, 0, 0, 0, 1); // set wins
        rd(8'h04);
        // R2: every independent channel
        for (int s = 0; s < 4; s++) begin
            step(1, 8'h00, 32'(s << 2) | 32'h1);
            step(0, 8'h04, '0, 1);
            step(0, 8'h04, '0, 0, 1);
            rd(8'h00);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule